// File: doc/BRIEF.md
# Dual-Processor Signal and Alert Controller

This block carries programmed and hardware messages between the two instruction processors of a dual-processor configuration. Each processor can present a signalling order, which is an 8-bit order code, to the controller. The order is always aimed at the other processor. The controller checks the code against the current architecture mode and answers the requester with a two-bit status one cycle later. When it accepts an order, it records the order as a pending request bit at the target, and the target clears that bit once it has taken it.

The controller also does the following:
- It answers store-CPU-address requests with the requester's own fixed address, which is 0 or 1.
- It flags pending external conditions together with the address of the processor that caused them.
- It raises a malfunction alert to the surviving processor when its peer stops its clock because of a machine check. The alert stays up until the survivor acknowledges it.

Top module: `ipc_signal_hub`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after reset with idle inputs, every output is 0.
- R2: An order presented while `ord_vld[i]` is high is answered on the next cycle. `ord_done[i]` is high and the status code appears on `ord_stat_pi`. The status codes are 00 accepted, 01 status stored, 10 busy and 11 not operational. An accepted order sets one bit of the peer's pending vector. The bits are: bit0 external call (code 0x02), bit1 emergency signal (0x03), bit2 stop (0x05), bit3 restart (0x06), bit4 CPU reset (0x0A) and bit5 initial CPU reset (0x09). Sense (0x01) is accepted and sets no bit.
- R3: When `mode_xa` is 0, the orders 0x09 and 0x0A return status stored with `ord_inval[i]` high and set no pending bit. When `mode_xa` is 1, both orders are accepted.
- R4: The IML order (0x0B), and any code not listed in R2, return status stored with `ord_inval[i]` high in both modes.
- R5: An implemented order whose pending bit is already set at the peer returns busy and leaves the pending vector unchanged.
- R6: When both processors present an order in the same cycle, processor 0 is served normally. Processor 1 gets busy whatever its code, and its order has no effect.
- R7: A valid implemented order returns not operational, and sets nothing, while the peer's `clk_stopped` is high. An invalid code still returns status stored.
- R8: A high bit of `pend_ack_pi` clears that bit of `pend_pi` on the next cycle.
- R9: A pulse on `cpu_addr_req[i]` gives `cpu_addr_vld[i]` high on the next cycle, with `cpu_addr_pi` equal to i.
- R10: A rising edge of `clk_stopped[j]` while `mchk_stop[j]` is high sets `malf_alert` of the other processor on the next cycle. The alert holds until that processor's `malf_ack`. It is raised once per stop event, even while the clock stays stopped. A stop without a machine check raises no alert.
- R11: `ext_pend[i]` is high while processor i has a malfunction alert or a pending external call or emergency signal. While it is high, `ext_src_pi` gives the peer's address (1-i).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_xa | input | 1 | Architecture mode: 0 base, 1 extended |
| ord_vld | input | 2 | Order request, one bit per processor |
| ord_code_p0 | input | 8 | Order code from processor 0 |
| ord_code_p1 | input | 8 | Order code from processor 1 |
| pend_ack_p0 | input | 6 | Pending-order clear mask from processor 0 |
| pend_ack_p1 | input | 6 | Pending-order clear mask from processor 1 |
| cpu_addr_req | input | 2 | Store-CPU-address request per processor |
| clk_stopped | input | 2 | Clock-stopped state per processor |
| mchk_stop | input | 2 | Stop caused by machine check, per processor |
| malf_ack | input | 2 | Malfunction alert acknowledge per processor |
| ord_done | output | 2 | Order response valid per processor |
| ord_stat_p0 | output | 2 | Order status returned to processor 0 |
| ord_stat_p1 | output | 2 | Order status returned to processor 1 |
| ord_inval | output | 2 | Invalid-order bit of the status word |
| pend_p0 | output | 6 | Orders pending at processor 0 |
| pend_p1 | output | 6 | Orders pending at processor 1 |
| cpu_addr_vld | output | 2 | Store-CPU-address answer valid |
| cpu_addr_p0 | output | 1 | Address returned to processor 0 |
| cpu_addr_p1 | output | 1 | Address returned to processor 1 |
| malf_alert | output | 2 | Malfunction alert pending per processor |
| ext_pend | output | 2 | External condition pending per processor |
| ext_src_p0 | output | 1 | Address of processor causing processor 0's condition |
| ext_src_p1 | output | 1 | Address of processor causing processor 1's condition |

## Verification
A pending bit that is stuck set shows up on the next order of the same type, which returns busy instead of accepted. A pending bit that is lost is visible on the pending outputs one cycle after the order. A wrong edge register in the malfunction path either raises a second alert after an acknowledge while the clock is still stopped, or raises no alert at all. Both show on `malf_alert` within two cycles. A fault in the mode or priority decode changes the status code in the very next response.

// File: rtl/ipc_pkg.sv
package ipc_pkg;
  localparam int NCPU  = 2;
  localparam int NTYPE = 6;
  localparam int CW    = 8;

  typedef enum logic [1:0] {
    ST_ACC    = 2'b00,
    ST_STORED = 2'b01,
    ST_BUSY   = 2'b10,
    ST_NOTOP  = 2'b11
  } stat_e;

  localparam logic [CW-1:0] OC_SENSE   = 8'h01;
  localparam logic [CW-1:0] OC_EXTCALL = 8'h02;
  localparam logic [CW-1:0] OC_EMERG   = 8'h03;
  localparam logic [CW-1:0] OC_STOP    = 8'h05;
  localparam logic [CW-1:0] OC_RESTART = 8'h06;
  localparam logic [CW-1:0] OC_INITRST = 8'h09;
  localparam logic [CW-1:0] OC_CPURST  = 8'h0A;
  localparam logic [CW-1:0] OC_IML     = 8'h0B;

  // pending vector bit positions
  localparam int T_EXT     = 0;
  localparam int T_EMERG   = 1;
  localparam int T_STOP    = 2;
  localparam int T_RESTART = 3;
  localparam int T_CPURST  = 4;
  localparam int T_INITRST = 5;

  function automatic logic [NTYPE-1:0] type_mask(input logic [CW-1:0] c);
    logic [NTYPE-1:0] m;
    m = '0;
    case (c)
      OC_EXTCALL: m[T_EXT]     = 1'b1;
      OC_EMERG:   m[T_EMERG]   = 1'b1;
      OC_STOP:    m[T_STOP]    = 1'b1;
      OC_RESTART: m[T_RESTART] = 1'b1;
      OC_CPURST:  m[T_CPURST]  = 1'b1;
      OC_INITRST: m[T_INITRST] = 1'b1;
      default:    m = '0;
    endcase
    return m;
  endfunction

  function automatic logic order_impl(input logic [CW-1:0] c, input logic xa);
    case (c)
      OC_SENSE, OC_EXTCALL, OC_EMERG, OC_STOP, OC_RESTART: return 1'b1;
      OC_CPURST, OC_INITRST: return xa;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic peer_of(input int idx);
    return (idx == 0) ? 1'b1 : 1'b0;
  endfunction
endpackage

// File: rtl/ipc_order_check.sv
module ipc_order_check
  import ipc_pkg::*;
(
  input  logic [CW-1:0]    code_i,
  input  logic             mode_xa_i,
  output logic             impl_o,
  output logic [NTYPE-1:0] tmask_o
);
  assign impl_o  = order_impl(code_i, mode_xa_i);
  assign tmask_o = type_mask(code_i);
endmodule

// File: rtl/ipc_pend_bank.sv
module ipc_pend_bank
  import ipc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NTYPE-1:0] set_i,
  input  logic [NTYPE-1:0] ack_i,
  output logic [NTYPE-1:0] pend_o
);
  always_ff @(posedge clk) begin
    if (!rst_n) pend_o <= '0;
    else        pend_o <= (pend_o & ~ack_i) | set_i;
  end

  // R8
  ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|(pend_o & ack_i & ~set_i)) |=> ((pend_o & $past(pend_o & ack_i & ~set_i)) == '0));
endmodule

// File: rtl/ipc_malf_alert.sv
module ipc_malf_alert (
  input  logic clk,
  input  logic rst_n,
  input  logic stop_i,
  input  logic mchk_i,
  input  logic ack_i,
  output logic alert_o
);
  logic stop_q;
  logic stop_evt;

  assign stop_evt = stop_i & ~stop_q & mchk_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stop_q  <= 1'b0;
      alert_o <= 1'b0;
    end else begin
      stop_q <= stop_i;
      if (stop_evt)   alert_o <= 1'b1;
      else if (ack_i) alert_o <= 1'b0;
    end
  end

  // R10
  malf_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(alert_o) |-> $past(stop_evt));
  // R10
  malf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (alert_o && !ack_i) |=> alert_o);
endmodule

// File: rtl/ipc_signal_hub.sv
module ipc_signal_hub
  import ipc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mode_xa,
  input  logic [1:0]       ord_vld,
  input  logic [7:0]       ord_code_p0,
  input  logic [7:0]       ord_code_p1,
  input  logic [5:0]       pend_ack_p0,
  input  logic [5:0]       pend_ack_p1,
  input  logic [1:0]       cpu_addr_req,
  input  logic [1:0]       clk_stopped,
  input  logic [1:0]       mchk_stop,
  input  logic [1:0]       malf_ack,
  output logic [1:0]       ord_done,
  output logic [1:0]       ord_stat_p0,
  output logic [1:0]       ord_stat_p1,
  output logic [1:0]       ord_inval,
  output logic [5:0]       pend_p0,
  output logic [5:0]       pend_p1,
  output logic [1:0]       cpu_addr_vld,
  output logic             cpu_addr_p0,
  output logic             cpu_addr_p1,
  output logic [1:0]       malf_alert,
  output logic [1:0]       ext_pend,
  output logic             ext_src_p0,
  output logic             ext_src_p1
);
  logic [NCPU-1:0][CW-1:0]    code_v;
  logic [NCPU-1:0][NTYPE-1:0] ack_v, pend_v, set_v;
  logic [NCPU-1:0][1:0]       stat_v;
  logic [NCPU-1:0]            addr_v, src_v;

  assign code_v[0] = ord_code_p0;
  assign code_v[1] = ord_code_p1;
  assign ack_v[0]  = pend_ack_p0;
  assign ack_v[1]  = pend_ack_p1;

  for (genvar i = 0; i < NCPU; i++) begin : g_cpu
    localparam int P = 1 - i;
    logic             impl_w;
    logic [NTYPE-1:0] tmask_w;
    logic             coll_w;
    stat_e            st_d, st_q;
    logic             inv_d, inv_q, done_q, addr_q;

    ipc_order_check u_chk (
      .code_i(code_v[i]), .mode_xa_i(mode_xa),
      .impl_o(impl_w), .tmask_o(tmask_w)
    );

    // processor 0 wins a same-cycle collision
    if (i == 0) begin : g_win
      assign coll_w = 1'b0;
    end else begin : g_lose
      assign coll_w = ord_vld[0];
    end

    always_comb begin
      inv_d = 1'b0;
      if (coll_w)                         st_d = ST_BUSY;
      else if (!impl_w) begin             st_d = ST_STORED; inv_d = 1'b1; end
      else if (clk_stopped[P])            st_d = ST_NOTOP;
      else if (|(tmask_w & pend_v[P]))    st_d = ST_BUSY;
      else                                st_d = ST_ACC;
    end

    assign set_v[P] = (ord_vld[i] && st_d == ST_ACC) ? tmask_w : '0;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        st_q   <= ST_ACC;
        inv_q  <= 1'b0;
        done_q <= 1'b0;
        addr_q <= 1'b0;
      end else begin
        st_q   <= ord_vld[i] ? st_d : ST_ACC;
        inv_q  <= ord_vld[i] & inv_d;
        done_q <= ord_vld[i];
        addr_q <= cpu_addr_req[i] ? 1'(i) : 1'b0;
      end
    end

    always_ff @(posedge clk) begin
      if (!rst_n) cpu_addr_vld[i] <= 1'b0;
      else        cpu_addr_vld[i] <= cpu_addr_req[i];
    end

    ipc_pend_bank u_pend (
      .clk(clk), .rst_n(rst_n), .set_i(set_v[i]),
      .ack_i(ack_v[i]), .pend_o(pend_v[i])
    );

    ipc_malf_alert u_malf (
      .clk(clk), .rst_n(rst_n), .stop_i(clk_stopped[P]),
      .mchk_i(mchk_stop[P]), .ack_i(malf_ack[i]), .alert_o(malf_alert[i])
    );

    assign stat_v[i]    = st_q;
    assign ord_done[i]  = done_q;
    assign ord_inval[i] = inv_q;
    assign addr_v[i]    = addr_q;
    assign ext_pend[i]  = malf_alert[i] | pend_v[i][T_EXT] | pend_v[i][T_EMERG];
    assign src_v[i]     = ext_pend[i] ? peer_of(i) : 1'b0;

    // R2
    pend_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|(pend_v[P] & ~$past(pend_v[P]))) |-> (done_q && st_q == ST_ACC));
    // R9
    addr_id_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_addr_req[i] |=> (cpu_addr_vld[i] && addr_v[i] == 1'(i)));
    // R4
    iml_rej_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ord_vld[i] && !coll_w && code_v[i] == OC_IML) |=> (inv_q && st_q == ST_STORED));
    // R2
    inval_stat_chk: assert property (@(posedge clk) disable iff (!rst_n)
      inv_q |-> (done_q && st_q == ST_STORED));
  end

  assign ord_stat_p0 = stat_v[0];
  assign ord_stat_p1 = stat_v[1];
  assign pend_p0     = pend_v[0];
  assign pend_p1     = pend_v[1];
  assign cpu_addr_p0 = addr_v[0];
  assign cpu_addr_p1 = addr_v[1];
  assign ext_src_p0  = src_v[0];
  assign ext_src_p1  = src_v[1];

  // R6
  coll_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ord_vld == 2'b11) |=> (ord_stat_p1 == ST_BUSY && !ord_inval[1]));
endmodule

// File: tb/test_ipc_signal_hub.sv
`timescale 1ns/100ps
module test_ipc_signal_hub;
  logic clk = 1'b0;
  logic rst_n;
  logic mode_xa;
  logic [1:0] ord_vld, cpu_addr_req, clk_stopped, mchk_stop, malf_ack;
  logic [7:0] ord_code_p0, ord_code_p1;
  logic [5:0] pend_ack_p0, pend_ack_p1;
  logic [1:0] ord_done, ord_stat_p0, ord_stat_p1, ord_inval;
  logic [5:0] pend_p0, pend_p1;
  logic [1:0] cpu_addr_vld, malf_alert, ext_pend;
  logic cpu_addr_p0, cpu_addr_p1, ext_src_p0, ext_src_p1;

  int checks = 0;
  int fails  = 0;
  bit done_run = 1'b0;

  always #2.5 clk = ~clk;

  ipc_signal_hub i_ipc_signal_hub (.*);

  typedef struct packed {
    logic       xa;
    logic [1:0] vld;
    logic [7:0] c0;
    logic [7:0] c1;
    logic [1:0] s0;
    logic       i0;
    logic [1:0] s1;
    logic       i1;
    logic [5:0] p0;
    logic [5:0] p1;
  } vec_t;

  // status: 0 acc, 1 stored, 2 busy, 3 not operational
  localparam int NV = 13;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 2'b01, 8'h02, 8'h00, 2'd0, 1'b0, 2'd0, 1'b0, 6'h00, 6'h01}, // R2
    '{1'b0, 2'b01, 8'h0A, 8'h00, 2'd1, 1'b1, 2'd0, 1'b0, 6'h00, 6'h00}, // R3
    '{1'b0, 2'b01, 8'h09, 8'h00, 2'd1, 1'b1, 2'd0, 1'b0, 6'h00, 6'h00}, // R3
    '{1'b1, 2'b01, 8'h0A, 8'h00, 2'd0, 1'b0, 2'd0, 1'b0, 6'h00, 6'h10}, // R3
    '{1'b1, 2'b01, 8'h09, 8'h00, 2'd0, 1'b0, 2'd0, 1'b0, 6'h00, 6'h20}, // R3
    '{1'b1, 2'b01, 8'h0B, 8'h00, 2'd1, 1'b1, 2'd0, 1'b0, 6'h00, 6'h00}, // R4
    '{1'b0, 2'b01, 8'h0B, 8'h00, 2'd1, 1'b1, 2'd0, 1'b0, 6'h00, 6'h00}, // R4
    '{1'b0, 2'b10, 8'h00, 8'h03, 2'd0, 1'b0, 2'd0, 1'b0, 6'h02, 6'h00}, // R2
    '{1'b0, 2'b11, 8'h05, 8'h06, 2'd0, 1'b0, 2'd2, 1'b0, 6'h00, 6'h04}, // R6
    '{1'b0, 2'b11, 8'h0B, 8'h02, 2'd1, 1'b1, 2'd2, 1'b0, 6'h00, 6'h00}, // R6
    '{1'b0, 2'b01, 8'h01, 8'h00, 2'd0, 1'b0, 2'd0, 1'b0, 6'h00, 6'h00}, // R2
    '{1'b0, 2'b01, 8'h07, 8'h00, 2'd1, 1'b1, 2'd0, 1'b0, 6'h00, 6'h00}, // R4
    '{1'b1, 2'b10, 8'h00, 8'h0A, 2'd0, 1'b0, 2'd0, 1'b0, 6'h10, 6'h00}  // R3
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic idle_inputs();
    ord_vld = '0; ord_code_p0 = '0; ord_code_p1 = '0;
    pend_ack_p0 = '0; pend_ack_p1 = '0; cpu_addr_req = '0; malf_ack = '0;
  endtask

  // drive at a falling edge, let one rising edge pass, return at the next falling edge
  task automatic send(input logic [1:0] v, input logic [7:0] c0, input logic [7:0] c1);
    ord_vld = v; ord_code_p0 = c0; ord_code_p1 = c1;
    @(negedge clk);
    ord_vld = '0; ord_code_p0 = '0; ord_code_p1 = '0;
  endtask

  task automatic ack_all();
    pend_ack_p0 = '1; pend_ack_p1 = '1; malf_ack = '1;
    @(negedge clk);
    pend_ack_p0 = '0; pend_ack_p1 = '0; malf_ack = '0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done_run) begin
      checks++; fails++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; mode_xa = 1'b0; clk_stopped = '0; mchk_stop = '0;
    idle_inputs();
    repeat (3) @(negedge clk);
    // R1 in reset
    chk("R1 outputs in reset", {ord_done, ord_stat_p0, ord_stat_p1, ord_inval, pend_p0, pend_p1,
        cpu_addr_vld, cpu_addr_p0, cpu_addr_p1, malf_alert, ext_pend, ext_src_p0, ext_src_p1}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 outputs after reset", {ord_done, ord_stat_p0, ord_stat_p1, ord_inval, pend_p0, pend_p1,
        cpu_addr_vld, cpu_addr_p0, cpu_addr_p1, malf_alert, ext_pend, ext_src_p0, ext_src_p1}, 0);

    for (int k = 0; k < NV; k++) begin
      mode_xa = VEC[k].xa;
      send(VEC[k].vld, VEC[k].c0, VEC[k].c1);
      chk($sformatf("R2/R3/R4/R6 vec%0d p0 rsp", k), {ord_done[0], ord_stat_p0, ord_inval[0]},
          {VEC[k].vld[0], VEC[k].s0, VEC[k].i0});
      chk($sformatf("R2/R3/R4/R6 vec%0d p1 rsp", k), {ord_done[1], ord_stat_p1, ord_inval[1]},
          {VEC[k].vld[1], VEC[k].s1, VEC[k].i1});
      chk($sformatf("R2 vec%0d pending", k), {pend_p0, pend_p1}, {VEC[k].p0, VEC[k].p1});
      ack_all();
    end
    mode_xa = 1'b0;

    // R5 same-type order already pending
    send(2'b01, 8'h02, 8'h00);
    chk("R5 first ext call accepted", {ord_stat_p0, pend_p1}, {2'd0, 6'h01});
    send(2'b01, 8'h02, 8'h00);
    chk("R5 repeat ext call busy", {ord_done[0], ord_stat_p0, pend_p1}, {1'b1, 2'd2, 6'h01});
    // R11 peer of processor 1 is address 0
    chk("R11 ext pend p1", {ext_pend, ext_src_p1}, {2'b10, 1'b0});
    // R8 ack clears the pending bit
    pend_ack_p1 = 6'h01;
    @(negedge clk);
    pend_ack_p1 = '0;
    chk("R8 ack clears pending", {pend_p1, ext_pend}, {6'h00, 2'b00});
    send(2'b01, 8'h02, 8'h00);
    chk("R5 accepted again after ack", {ord_stat_p0, pend_p1}, {2'd0, 6'h01});
    ack_all();

    // R11 emergency signal from processor 1 to processor 0
    send(2'b10, 8'h00, 8'h03);
    chk("R11 ext pend p0 src", {ext_pend, ext_src_p0, pend_p0}, {2'b01, 1'b1, 6'h02});
    ack_all();

    // R7 peer clock stopped, no machine check
    clk_stopped = 2'b10;
    send(2'b01, 8'h05, 8'h00);
    chk("R7 not operational", {ord_done[0], ord_stat_p0, ord_inval[0], pend_p1}, {1'b1, 2'd3, 1'b0, 6'h00});
    send(2'b01, 8'h0B, 8'h00);
    chk("R7 invalid before not-op", {ord_stat_p0, ord_inval[0]}, {2'd1, 1'b1});
    chk("R10 no alert without machine check", malf_alert, 2'b00);
    clk_stopped = 2'b00;
    @(negedge clk);

    // R10 machine-check stop of processor 1 alerts processor 0
    mchk_stop = 2'b10; clk_stopped = 2'b10;
    @(negedge clk);
    chk("R10 alert raised", malf_alert, 2'b01);
    chk("R11 alert tags source", {ext_pend[0], ext_src_p0}, {1'b1, 1'b1});
    repeat (3) @(negedge clk);
    chk("R10 alert held", malf_alert, 2'b01);
    malf_ack = 2'b01;
    @(negedge clk);
    malf_ack = '0;
    chk("R10 alert cleared by ack", malf_alert, 2'b00);
    repeat (3) @(negedge clk);
    chk("R10 one alert per stop event", malf_alert, 2'b00);
    clk_stopped = 2'b00; mchk_stop = 2'b00;
    @(negedge clk);
    // R10 machine-check stop of processor 0 alerts processor 1
    mchk_stop = 2'b01; clk_stopped = 2'b01;
    @(negedge clk);
    chk("R10 alert to p1", malf_alert, 2'b10);
    clk_stopped = 2'b00; mchk_stop = 2'b00;
    ack_all();

    // R9 store CPU address
    cpu_addr_req = 2'b11;
    @(negedge clk);
    cpu_addr_req = '0;
    chk("R9 both addresses", {cpu_addr_vld, cpu_addr_p0, cpu_addr_p1}, {2'b11, 1'b0, 1'b1});
    cpu_addr_req = 2'b10;
    @(negedge clk);
    cpu_addr_req = '0;
    chk("R9 p1 address", {cpu_addr_vld, cpu_addr_p1}, {2'b10, 1'b1});

    done_run = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule